// File: doc/BRIEF.md
# Survivor Traceback for a 256-State Trellis Decoder

This block sits behind the add-compare-select stage of a trellis decoder for a rate-agnostic binary convolutional code with eight delay elements (256 states). For every trellis step it receives one decision vector, one bit per state. Each bit tells which of the two possible predecessors won for that state. The vectors of a whole terminated frame are kept in survivor storage.

When the frame is closed, the block walks the trellis backward from the all-zero final state, one step per clock. At each step it reads the stored decision bit of the current state and forms the predecessor state. The decoded bit of that step is the top bit of the current state. The bits appear newest-first, so a last-in first-out buffer turns them around. The block then streams the data bits in forward time order and drops the zero tail steps that closed the frame. While it walks and streams, the block reports itself busy and does not accept a new frame.

Top module: `vtb_traceback`

## Requirements
- R1: A synchronous active-low reset, also when applied in the middle of a traceback, leaves `busy` and `out_valid` low and the stored step count at zero, so that the next frame starts from step 0.
- R2: While idle, each `dec_valid` cycle stores `dec_vec` as the next trellis step, starting at step 0. Once `LEN` steps are stored, further vectors are ignored until the frame has been processed.
- R3: The backward walk starts in state 0 at the last stored step. From current state `s` at step `t`, the predecessor is `{s[SB-2:0], d}`, where `d` is bit number `s` of the vector stored for step `t`. Decision bits at any other position have no effect.
- R4: The decoded bit of step `t` is the most significant bit of the state that the walk holds at step `t`.
- R5: With `n` steps stored, the last `SB` steps (the tail) are dropped and exactly `n-SB` bits are output; no bits are output when `n <= SB`. A `frame_end` with no steps stored leaves the block idle.
- R6: Data bits leave in forward order: the first output bit belongs to step 0.
- R7: `busy` rises at the clock edge that samples `frame_end` and falls after `n + max(n-SB,0)` further edges. Every `dec_valid` and `frame_end` seen while `busy` is high is ignored.
- R8: `out_valid` is high only while `busy` is high. It first rises `n` edges after the edge that raised `busy`, and it stays high in consecutive cycles until the last bit has been delivered.
- R9: A vector presented together with `frame_end` is stored as the final step of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | `dec_vec` holds the decisions of the next trellis step |
| dec_vec | input | 2**SB | One decision bit per state, bit index = state number |
| frame_end | input | 1 | Closes the frame and starts the traceback |
| busy | output | 1 | Traceback or output in progress; inputs are ignored |
| out_valid | output | 1 | `out_bit` carries a decoded data bit |
| out_bit | output | 1 | Decoded data bit, oldest first |

## Verification
The bench builds the block with SB=4 (16 states, 4 tail steps) and LEN=12. With these values a full frame of 8 data bits, the storage limit and the tail-only frames are all reached in a few dozen cycles. The bench generates decision vectors from chosen input bit patterns. It sets only the bits on the true path and fills all other positions with patterns that would mislead a walk reading the wrong entry. Short frames, frames of exactly the tail length, a frame with no steps, surplus writes, a `frame_end` that coincides with a write, input traffic during busy and a reset in the middle of a walk are all placed where the timing of `busy` and `out_valid` can be counted edge by edge.

// File: rtl/vtb_pkg.sv
// Package: shared phase encoding for the traceback unit.
// Assumes: nothing beyond the three phases named here.
package vtb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRACE = 2'd1,
        PH_DRAIN = 2'd2
    } vtb_phase_e;
endpackage

// File: rtl/vtb_store.sv
// Survivor storage: one decision vector per trellis step.
// Does: writes a full vector per step and reads a single decision bit
//       addressed by step and state, combinationally.
// Assumes: the caller keeps wr_addr below the frame length; rows above the
//       frame length exist only to keep the address decode exact.
module vtb_store #(
    parameter int SB  = 8,
    parameter int AW  = 6,
    localparam int NST  = 1 << SB,
    localparam int ROWS = 1 << AW
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [NST-1:0] wr_vec,
    input  logic [AW-1:0]  rd_addr,
    input  logic [SB-1:0]  rd_sel,
    output logic           rd_bit
);
    logic [NST-1:0] rows [ROWS];

    // Store the decision vector of the addressed step.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows[wr_addr] <= wr_vec;
        end
    end

    // Pick the decision bit of the current state in the current step.
    always_comb begin
        rd_bit = rows[rd_addr][rd_sel];
    end
endmodule

// File: rtl/vtb_walker.sv
// Backward trellis walker.
// Does: holds the current state and step; on load it starts in state 0 at
//       the given step, on advance it moves to the predecessor state
//       {state[SB-2:0], decision} and to the previous step.
// Assumes: load and advance are never asserted together.
module vtb_walker #(
    parameter int SB = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_step,
    input  logic          advance,
    input  logic          dec_bit,
    output logic [SB-1:0] cur_state,
    output logic [AW-1:0] cur_step,
    output logic          out_bit
);
    // Update state and step for a new walk or one backward move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= '0;
            cur_step  <= '0;
        end else if (load) begin
            cur_state <= '0;
            cur_step  <= load_step;
        end else if (advance) begin
            cur_state <= {cur_state[SB-2:0], dec_bit};
            cur_step  <= cur_step - AW'(1);
        end
    end

    // The bit that entered the encoder at this step is the state's top bit.
    always_comb begin
        out_bit = cur_state[SB-1];
    end
endmodule

// File: rtl/vtb_lifo.sv
// Single-bit last-in first-out buffer that reverses the decoded bit order.
// Does: pushes at the top, pops from the top, reports its fill level.
// Assumes: push and pop are never asserted together, no pop when empty,
//       and never more pushes than slots.
module vtb_lifo #(
    parameter int CW = 7,
    localparam int SLOTS = 1 << CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_bit,
    input  logic          pop,
    output logic          top_bit,
    output logic [CW-1:0] level
);
    logic [SLOTS-1:0] slots;

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (push) begin
            level <= level + CW'(1);
        end else if (pop) begin
            level <= level - CW'(1);
        end
    end

    // Write the pushed bit into the next free slot.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[level] <= push_bit;
        end
    end

    // Present the most recently pushed bit.
    always_comb begin
        top_bit = slots[level - CW'(1)];
    end
endmodule

// File: rtl/vtb_traceback.sv
// Top: survivor traceback for a terminated trellis frame.
// Does: collects up to LEN decision vectors; on frame_end it walks back from
//       state 0 one step per cycle, buffers the data bits of the non-tail
//       steps, then streams them oldest first, one per cycle.
// Assumes: the frame was driven into state 0 by SB zero tail inputs.
module vtb_traceback #(
    parameter int SB  = 8,
    parameter int LEN = 64,
    localparam int NST      = 1 << SB,
    localparam int TAIL     = SB,
    localparam int AW       = $clog2(LEN),
    localparam int CW       = $clog2(LEN + 1),
    localparam int DATA_MAX = LEN - TAIL
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dec_valid,
    input  logic [NST-1:0] dec_vec,
    input  logic           frame_end,
    output logic           busy,
    output logic           out_valid,
    output logic           out_bit
);
    import vtb_pkg::*;

    vtb_phase_e    phase;
    logic [CW-1:0] wr_cnt;
    logic          wr_ok;
    logic [CW-1:0] n_total;
    logic [CW-1:0] data_n;
    logic          load;
    logic          advance;
    logic          push;
    logic          pop;
    logic          dec_bit;
    logic          walk_bit;
    logic [SB-1:0] cur_state;
    logic [AW-1:0] cur_step;
    logic [CW-1:0] lifo_level;

    // Derive write acceptance, frame size and per-phase strobes.
    always_comb begin
        wr_ok   = (phase == PH_IDLE) && dec_valid && (wr_cnt < CW'(LEN));
        n_total = wr_cnt + CW'(wr_ok);
        data_n  = (wr_cnt > CW'(TAIL)) ? (wr_cnt - CW'(TAIL)) : '0;
        load    = (phase == PH_IDLE) && frame_end && (n_total != '0);
        advance = (phase == PH_TRACE);
        push    = (phase == PH_TRACE) && (CW'(cur_step) < data_n);
        pop     = (phase == PH_DRAIN);
    end

    // Sequence the phases and count stored steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            wr_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    wr_cnt <= n_total;
                    if (load) begin
                        phase <= PH_TRACE;
                    end
                end
                PH_TRACE: begin
                    if (cur_step == '0) begin
                        if (data_n != '0) begin
                            phase <= PH_DRAIN;
                        end else begin
                            phase  <= PH_IDLE;
                            wr_cnt <= '0;
                        end
                    end
                end
                PH_DRAIN: begin
                    if (lifo_level == CW'(1)) begin
                        phase  <= PH_IDLE;
                        wr_cnt <= '0;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Drive the outward status and stream strobes.
    always_comb begin
        busy      = (phase != PH_IDLE);
        out_valid = (phase == PH_DRAIN);
    end

    vtb_store #(.SB(SB), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_ok),
        .wr_addr (AW'(wr_cnt)),
        .wr_vec  (dec_vec),
        .rd_addr (cur_step),
        .rd_sel  (cur_state),
        .rd_bit  (dec_bit)
    );

    vtb_walker #(.SB(SB), .AW(AW)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_step (AW'(n_total - CW'(1))),
        .advance   (advance),
        .dec_bit   (dec_bit),
        .cur_state (cur_state),
        .cur_step  (cur_step),
        .out_bit   (walk_bit)
    );

    vtb_lifo #(.CW(CW)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_bit (walk_bit),
        .pop      (pop),
        .top_bit  (out_bit),
        .level    (lifo_level)
    );
endmodule

// File: rtl/vtb_checker.sv
// Checker for the traceback unit: timing rules of busy, the output burst
// and the reversal buffer. Attached to every instance of the top by bind.
module vtb_checker #(
    parameter int LW   = 7,
    parameter int DMAX = 56
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_end,
    input logic          busy,
    input logic          out_valid,
    input logic [LW-1:0] lifo_level
);
    // R8: output only while the block is busy
    p_out_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R8: once started, the burst runs without gaps until busy drops
    p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (out_valid || !busy));

    // R7: busy only ever starts from a sampled frame_end
    p_busy_from_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_end));

    // R5: never more buffered bits than data steps in a full frame
    p_lifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lifo_level <= LW'(DMAX));

    // R6: the burst ends exactly when the reversal buffer is empty
    p_drain_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (lifo_level == '0));
endmodule

bind vtb_traceback vtb_checker #(.LW(CW), .DMAX(DATA_MAX)) u_vtb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .busy       (busy),
    .out_valid  (out_valid),
    .lifo_level (lifo_level)
);

// File: tb/vtb_traceback_bench.sv
module vtb_traceback_bench;
    localparam int SB         = 4;
    localparam int LEN        = 12;
    localparam int TAIL       = SB;
    localparam int NST        = 1 << SB;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    // Stimulus table: {steps n, data bits (bit t = step t), filler pattern}
    localparam logic [31:0] TABLE [NVEC] = '{
        {8'd12, 8'hA5, 16'h0000},
        {8'd12, 8'h3C, 16'hFFFF},
        {8'd10, 8'h2D, 16'h5A5A},
        {8'd5,  8'h01, 16'hC3C3},
        {8'd12, 8'hFF, 16'h1234},
        {8'd7,  8'h06, 16'h0F0F}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           dec_valid;
    logic [NST-1:0] dec_vec;
    logic           frame_end;
    logic           busy;
    logic           out_valid;
    logic           out_bit;

    int checks   = 0;
    int failures = 0;

    vtb_traceback #(.SB(SB), .LEN(LEN)) u_vtb_traceback (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .dec_vec   (dec_vec),
        .frame_end (frame_end),
        .busy      (busy),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write n steps generated from data, close the frame, collect and check.
    task automatic run_frame(input int n, input logic [7:0] data, input logic [15:0] fill,
                             input int extra, input bit conc, input bit junk);
        logic [SB-1:0] sp;
        logic [SB-1:0] sn;
        logic          u;
        logic [NST-1:0] vec;
        int nd, got_n, first_j, j, mask;
        logic [7:0] got;
        nd = (n > TAIL) ? n - TAIL : 0;
        sp = '0;
        got = '0;
        got_n = 0;
        first_j = -1;
        for (int t = 0; t < n; t++) begin
            u   = (t < nd) ? data[t] : 1'b0;
            sn  = {u, sp[SB-1:1]};
            vec = fill ^ {4{4'(t)}};
            vec[sn] = sp[0];
            dec_valid = 1'b1;
            dec_vec   = vec;
            frame_end = conc && (t == n - 1) && (extra == 0);
            @(negedge clk);
            sp = sn;
        end
        for (int e = 0; e < extra; e++) begin
            dec_valid = 1'b1;
            dec_vec   = 16'hBEEF ^ 16'(e);
            frame_end = 1'b0;
            @(negedge clk);
        end
        if (!conc || extra != 0) begin
            dec_valid = 1'b0;
            frame_end = 1'b1;
            @(negedge clk);
        end
        dec_valid = 1'b0;
        frame_end = 1'b0;
        check(busy == 1'b1, "R7 busy after frame_end", int'(busy), 1);
        j = 0;
        while (busy && j < 200) begin
            if (out_valid) begin
                if (first_j < 0) first_j = j;
                if (got_n < 8) got[got_n] = out_bit;
                got_n++;
            end
            if (junk && j >= 1 && j <= 3) begin
                dec_valid = 1'b1;
                dec_vec   = 16'hFFFF;
                frame_end = (j == 2);
            end else begin
                dec_valid = 1'b0;
                frame_end = 1'b0;
            end
            @(negedge clk);
            j++;
        end
        dec_valid = 1'b0;
        frame_end = 1'b0;
        mask = (1 << nd) - 1;
        check(got_n == nd, "R5 output bit count", got_n, nd);
        check(j == n + nd, "R7 busy duration", j, n + nd);
        if (nd > 0) begin
            check(first_j == n, "R8 first out_valid cycle", first_j, n);
            check((int'(got) & mask) == (int'(data) & mask),
                  "R3 R4 R6 decoded bits", int'(got) & mask, int'(data) & mask);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        dec_valid = 1'b0;
        dec_vec   = '0;
        frame_end = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of frames: R3, R4, R5, R6 under varied data and filler
        for (int i = 0; i < NVEC; i++) begin
            run_frame(int'(TABLE[i][31:24]), TABLE[i][23:16], TABLE[i][15:0], 0, 1'b0, 1'b0);
        end

        // R5: tail-only frame gives no bits
        run_frame(TAIL, 8'h00, 16'hAAAA, 0, 1'b0, 1'b0);
        run_frame(3, 8'h00, 16'h5555, 0, 1'b0, 1'b0);

        // R5: frame_end with nothing stored keeps the block idle
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        check(busy == 1'b0, "R5 empty frame_end ignored", int'(busy), 0);
        @(negedge clk);

        // R9: vector together with frame_end is the last step
        run_frame(12, 8'h96, 16'h7E7E, 0, 1'b1, 1'b0);
        run_frame(6, 8'h02, 16'h3333, 0, 1'b1, 1'b0);

        // R2: surplus writes beyond LEN are dropped
        run_frame(12, 8'h4B, 16'hF00F, 3, 1'b0, 1'b0);

        // R7: traffic during busy is ignored; the next frame proves it
        run_frame(12, 8'hC6, 16'h0000, 0, 1'b0, 1'b1);
        run_frame(9, 8'h1B, 16'h9999, 0, 1'b0, 1'b0);

        // R1: reset in the middle of a walk
        for (int t = 0; t < 12; t++) begin
            dec_valid = 1'b1;
            dec_vec   = 16'h1111 << (t % 4);
            @(negedge clk);
        end
        dec_valid = 1'b0;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 mid-walk reset busy", int'(busy), 0);
        check(out_valid == 1'b0, "R1 mid-walk reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(8, 8'h0D, 16'h6666, 0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule